// File: doc/BRIEF.md
# Program Status Polling Responder

This block decides what a host sees on the 16-bit read bus of a nonvolatile memory. During an internal program cycle, stored data is not returned. Instead the block returns a status word built from the last word the host loaded. That word carries two completion indicators, and each one is repeated in both bytes. The first is a complemented bit: bit 7 of each byte is the inverse of the loaded word's bit. The second is a toggle bit: bit 6 of each byte changes value with every completed read. When the cycle ends, reads return the array data unchanged. The output-enable tri-state driver is modelled as a data-valid flag. While that flag is low, the data bus is forced to zero.

The busy flag comes from outside the block. Reads are decoded from active-low chip select, output enable and write enable, and no address is used. Every read made while busy is a status read. A small state machine tracks the busy period and the read strobe. It has three states. `ST_IDLE` means not busy. `ST_ARMED` means busy with no read in progress. `ST_READING` means busy with a read in progress.

The transitions are as follows. Busy rising takes `ST_IDLE` to `ST_ARMED`, or to `ST_READING` if a read is already active. A read starting takes `ST_ARMED` to `ST_READING`. A read ending takes `ST_READING` to `ST_ARMED`, and this is the only transition that inverts the toggle flop. Busy falling takes any state to `ST_IDLE`, and the toggle flop is cleared to 0 on that transition.

Top module: `status_poll_responder`

## Requirements
- R1: `rd_valid_o` is 1 exactly when `cs_n_i`=0, `oe_n_i`=0 and `we_n_i`=1, with no cycle of delay. While `rd_valid_o` is 0, `rd_data_o` is all zeros.
- R2: While `busy_i`=1 and a read is valid, `rd_data_o[7]` is the inverse of `last_word_i[7]` and `rd_data_o[15]` is the inverse of `last_word_i[15]`.
- R3: While busy, `rd_data_o[6]` and `rd_data_o[14]` both show the toggle value. That value is 0 on the first read of a busy period and inverts after each read that completes while busy.
- R4: The toggle value changes only when a read completes, in the clock after the strobe ends. A read held for several cycles shows one constant value, and idle clock cycles do not change it.
- R5: While busy, bits 0–5 and 8–13 of `rd_data_o` equal the same bits of `last_word_i`.
- R6: While busy, `array_data_i` has no effect on `rd_data_o`.
- R7: While `busy_i`=0, a valid read returns `array_data_i` unchanged on all 16 bits. This includes a read in the same cycle that busy falls.
- R8: Each new busy period starts its toggle value at 0, whatever value the previous period ended with.
- R9: A read that is still active when busy falls switches to true data at once and does not invert the toggle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busy_i | input | 1 | Internal program cycle in progress |
| last_word_i | input | 16 | Last word loaded by the host |
| array_data_i | input | 16 | Stored data at the read address |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| rd_data_o | output | 16 | Read data or status word |
| rd_valid_o | output | 1 | Bus driven; 0 models high impedance |

## Verification
The bench sweeps many loaded words through busy periods made of reads of 1 to 3 cycles, and changes the array data on every cycle. Three corner cases get particular attention:
- Toggle timing. Long reads and idle gaps are used to catch a toggle that advances on every clock or on the rising edge of the strobe; either would show a changing bit 6 within one read.
- Toggle restart. Busy periods that end with the toggle at 1 catch a toggle that is not restarted, because the next period's first read would return 1.
- Busy falling mid-read. Reads that straddle the fall of busy catch a registered busy path, which would return one stale status word, and catch a toggle that inverts when that read completes.

// File: rtl/poll_resp_pkg.sv
package poll_resp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_READING = 2'd2
    } poll_state_e;

endpackage

// File: rtl/bus_access_decode.sv
module bus_access_decode (
    input  logic cs_n_i,
    input  logic oe_n_i,
    input  logic we_n_i,
    output logic rd_active_o
);
    always_comb begin
        rd_active_o = (!cs_n_i) && (!oe_n_i) && we_n_i;
    end
endmodule

// File: rtl/toggle_tracker.sv
module toggle_tracker
    import poll_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic rd_active_i,
    output logic toggle_o
);
    poll_state_e state_q, state_d;
    logic        toggle_q, toggle_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            toggle_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            toggle_q <= toggle_d;
        end
    end

    // next state and toggle
    always_comb begin
        state_d  = state_q;
        toggle_d = toggle_q;
        unique case (state_q)
            ST_IDLE: begin
                toggle_d = 1'b0;
                if (busy_i) state_d = rd_active_i ? ST_READING : ST_ARMED;
            end
            ST_ARMED: begin
                if (!busy_i) begin
                    state_d  = ST_IDLE;
                    toggle_d = 1'b0;
                end else if (rd_active_i) begin
                    state_d = ST_READING;
                end
            end
            ST_READING: begin
                if (!busy_i) begin
                    state_d  = ST_IDLE;
                    toggle_d = 1'b0;
                end else if (!rd_active_i) begin
                    state_d  = ST_ARMED;
                    toggle_d = ~toggle_q;
                end
            end
            default: begin
                state_d  = ST_IDLE;
                toggle_d = 1'b0;
            end
        endcase
    end

    assign toggle_o = toggle_q;
endmodule

// File: rtl/status_lane.sv
module status_lane #(
    parameter int LANE_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              busy_i,
    input  logic              toggle_i,
    input  logic [LANE_W-1:0] last_lane_i,
    input  logic [LANE_W-1:0] array_lane_i,
    output logic [LANE_W-1:0] lane_o
);
    logic [LANE_W-1:0] status_lane;

    always_comb begin
        status_lane             = last_lane_i;
        status_lane[POLL_BIT]   = ~last_lane_i[POLL_BIT];
        status_lane[TOGGLE_BIT] = toggle_i;
        lane_o = busy_i ? status_lane : array_lane_i;
    end
endmodule

// File: rtl/status_poll_responder.sv
module status_poll_responder #(
    parameter int DATA_W     = 16,
    parameter int LANE_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] last_word_i,
    input  logic [DATA_W-1:0] array_data_i,
    input  logic              cs_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    logic              rd_active;
    logic              toggle;
    logic [DATA_W-1:0] word;

    bus_access_decode u_decode (
        .cs_n_i      (cs_n_i),
        .oe_n_i      (oe_n_i),
        .we_n_i      (we_n_i),
        .rd_active_o (rd_active)
    );

    toggle_tracker u_toggle (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_i),
        .rd_active_i (rd_active),
        .toggle_o    (toggle)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        status_lane #(
            .LANE_W     (LANE_W),
            .POLL_BIT   (POLL_BIT),
            .TOGGLE_BIT (TOGGLE_BIT)
        ) u_lane (
            .busy_i       (busy_i),
            .toggle_i     (toggle),
            .last_lane_i  (last_word_i[l*LANE_W +: LANE_W]),
            .array_lane_i (array_data_i[l*LANE_W +: LANE_W]),
            .lane_o       (word[l*LANE_W +: LANE_W])
        );
    end

    assign rd_valid_o = rd_active;
    assign rd_data_o  = rd_active ? word : '0;
endmodule

// File: rtl/poll_responder_checker.sv
module poll_responder_checker #(
    parameter int DATA_W     = 16,
    parameter int LANE_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_i,
    input logic [DATA_W-1:0] last_word_i,
    input logic [DATA_W-1:0] array_data_i,
    input logic              cs_n_i,
    input logic              oe_n_i,
    input logic              we_n_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              rd_valid_o
);
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam logic [LANE_W-1:0] KEEP =
        ~((LANE_W'(1) << POLL_BIT) | (LANE_W'(1) << TOGGLE_BIT));

    logic rd_req;
    assign rd_req = !cs_n_i && !oe_n_i && we_n_i;

    a_r1_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> rd_data_o == '0);

    a_r1_valid_decode: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o == rd_req);

    a_r7_true_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && rd_valid_o) |-> rd_data_o == array_data_i);

    a_r4_stable_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_valid_o && $past(busy_i && rd_valid_o))
            |-> $stable(rd_data_o[TOGGLE_BIT]));

    a_r8_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_i) && rd_valid_o) |-> !rd_data_o[TOGGLE_BIT]);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
        a_r2_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_i && rd_valid_o) |->
                rd_data_o[l*LANE_W+POLL_BIT] != last_word_i[l*LANE_W+POLL_BIT]);
        a_r3_lane_mirror: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_i && rd_valid_o) |->
                rd_data_o[l*LANE_W+TOGGLE_BIT] == rd_data_o[TOGGLE_BIT]);
        a_r5_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_i && rd_valid_o) |->
                ((rd_data_o[l*LANE_W +: LANE_W] ^ last_word_i[l*LANE_W +: LANE_W]) & KEEP) == '0);
    end
endmodule

bind status_poll_responder poll_responder_checker #(
    .DATA_W     (DATA_W),
    .LANE_W     (LANE_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .last_word_i  (last_word_i),
    .array_data_i (array_data_i),
    .cs_n_i       (cs_n_i),
    .oe_n_i       (oe_n_i),
    .we_n_i       (we_n_i),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o)
);

// File: tb/test_status_poll_responder.sv
module test_status_poll_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic [15:0] last_w = '0;
    logic [15:0] arr = '0;
    logic        cs_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [15:0] rd_data;
    logic        rd_valid;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    bit exp_tog = 1'b0;

    always #2 clk = ~clk;

    status_poll_responder i_status_poll_responder (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy),
        .last_word_i  (last_w),
        .array_data_i (arr),
        .cs_n_i       (cs_n),
        .oe_n_i       (oe_n),
        .we_n_i       (we_n),
        .rd_data_o    (rd_data),
        .rd_valid_o   (rd_valid)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // check a busy status read against the computed status fields
    task automatic check_status(input string ttag);
        check("R1 valid", {15'd0, rd_valid}, 16'd1);
        check("R2 poll bits", {14'd0, rd_data[15], rd_data[7]},
              {14'd0, ~last_w[15], ~last_w[7]});
        check(ttag, {14'd0, rd_data[14], rd_data[6]}, {14'd0, exp_tog, exp_tog});
        check("R5 kept bits", rd_data & 16'h3F3F, last_w & 16'h3F3F);
    endtask

    task automatic set_read(input bit on);
        cs_n = !on;
        oe_n = !on;
        we_n = 1'b1;
    endtask

    // one busy-period read of len cycles, array data changed every cycle (R6)
    task automatic busy_read(input int len, input int seed);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            set_read(1'b1);
            arr = 16'(seed * 16'h2F1B + c * 16'h0999);
            #1;
            check_status(c == 0 ? "R3 toggle" : "R4 held read");
            check("R6 array ignored", rd_data,
                  {~last_w[15], exp_tog, last_w[13:8], ~last_w[7], exp_tog, last_w[5:0]});
        end
        @(negedge clk);
        set_read(1'b0);
        #1;
        check("R1 idle zero", {rd_valid, rd_data[14:0]}, 16'd0);
        exp_tog = ~exp_tog;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset idle", {15'd0, rd_valid}, 16'd0);
        rst_n = 1'b1;

        // R1: every control combination, not busy
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            arr  = 16'hA5C3 ^ 16'(k);
            cs_n = k[0];
            oe_n = k[1];
            we_n = k[2];
            #1;
            if (k == 4) check("R1 read data", rd_data, arr);
            else        check("R1 no drive", {15'd0, rd_valid} | rd_data, 16'd0);
        end
        @(negedge clk);
        set_read(1'b0);

        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            last_w  = 16'(i * 16'h1357) ^ 16'(i << 9) ^ ((i % 3 == 0) ? 16'h8080 : 16'h0000);
            busy    = 1'b1;
            exp_tog = 1'b0;
            // R8: first read of every period shows 0
            for (int r = 0; r < 3 + (i % 3); r++) begin
                busy_read(1 + ((r + i) % 3), i * 7 + r);
                // idle gap must not move toggle (R4)
                repeat (i % 2 + 1) @(negedge clk);
            end
            if (i % 2 == 1) begin
                // R9: read straddles the fall of busy
                @(negedge clk);
                set_read(1'b1);
                #1;
                check_status("R8 period toggle");
                @(negedge clk);
                busy = 1'b0;
                arr  = 16'h5A00 ^ 16'(i);
                #1;
                check("R9 true at fall", rd_data, arr);
                @(negedge clk);
                #1;
                check("R9 still true", rd_data, arr);
                set_read(1'b0);
            end else begin
                @(negedge clk);
                busy = 1'b0;
                set_read(1'b1);
                arr = 16'hC300 ^ 16'(i * 5);
                #1;
                check("R7 first read after busy", rd_data, arr);
                @(negedge clk);
                set_read(1'b0);
            end
        end

        // R8/R9: a period after a straddled read starts at 0 and reads cleanly
        @(negedge clk);
        busy = 1'b1;
        last_w = 16'h00FF;
        exp_tog = 1'b0;
        busy_read(2, 99);
        busy_read(1, 98);
        @(negedge clk);
        busy = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule